// File: doc/BRIEF.md
# Unified Transform and Carry Address Generator

This block issues the group addresses for an in-place, memory-based radix-16 number theoretic transform of 65536 points. The transform runs in four stages of 4096 butterflies, and each butterfly reads or writes one group of 16 samples. A single path computes every address. A base counter is rotated right, and the rotated value is then optionally reversed in radix-16 digits. The same path serves the forward transform, the inverse transform and the final carry-resolution pass.

A start pulse launches a run in the mode given on two control inputs. While the run lasts, the block issues one address per cycle with `valid` high and reports the current stage. A one-cycle `done` pulse marks the end of the run. The memory arrays, the reordering buffer and all arithmetic are outside this block.

Top module: `ntt_addr_gen`

## Requirements
- R1: After reset, `valid`, `done`, `stage` and `addr` are all 0.
- R2: A start pulse with a legal mode (`rot_sel`,`rev_en` not both 1) seen on a clock edge while idle makes `valid` high from that edge on, and the first address uses base count 0 in stage 0.
- R3: With `rot_sel`=0 and `rev_en`=0 (forward), `addr` equals the base count rotated right by 4×`stage` bits. The rotation is taken modulo the address width.
- R4: With `rot_sel`=0 and `rev_en`=1 (inverse), `addr` is the R3 address with its 4-bit digits in reverse order. Digit 0 (bits 3:0) is swapped with the top digit.
- R5: With `rot_sel`=1 and `rev_en`=0 (carry resolution), there is a single pass in stage 0. The rotation is the constant `CARRY_ROT_DIGITS`×4 bits, which defaults to 0 and then gives sequential addresses.
- R6: In forward and inverse modes, `stage` runs from 0 up to `NUM_STAGES`-1 (0 to 3 by default). Each stage lasts 4096 consecutive valid cycles with the base count stepping by 1, and there are no gaps between stages.
- R7: `done` is high for exactly one cycle. That cycle immediately follows the last valid address, and `valid` is low during it.
- R8: A start with mode code 11 is ignored: `valid` and `done` stay low.
- R9: A start pulse during a run is ignored. The run continues in its original mode and sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when idle |
| rot_sel | input | 1 | 0: rotation taken from stage, 1: constant rotation |
| rev_en | input | 1 | Enables digit reversal of the address |
| addr | output | ADDR_W (12) | Sample-group address |
| stage | output | STG_W (2) | Current stage index |
| valid | output | 1 | Address is valid this cycle |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The start input is sampled on a clock edge. The first address is therefore due in the cycle that follows that edge. Each later address is due exactly one cycle after the one before it, and `done` is due one cycle after the last address. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every expected value is compared in the cycle it is due. The bench uses a reduced configuration (2-bit digits, two digits, three stages, carry rotation of one digit) so that it can sweep every address of every mode. The expected address is computed by integer division and remainder in base 4.

// File: rtl/ntt_addr_gen.sv
module ntt_addr_gen #(
  parameter int DIGIT_W          = 4,
  parameter int DIGITS           = 3,
  parameter int CARRY_ROT_DIGITS = 0,
  parameter int ADDR_W           = DIGIT_W * DIGITS,
  parameter int NUM_STAGES       = DIGITS + 1,
  parameter int STG_W            = (NUM_STAGES > 2) ? $clog2(NUM_STAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rot_sel,
  input  logic              rev_en,
  output logic [ADDR_W-1:0] addr,
  output logic [STG_W-1:0]  stage,
  output logic              valid,
  output logic              done
);
  localparam logic [ADDR_W-1:0] CNT_MAX    = '1;
  localparam logic [STG_W-1:0]  LAST_STAGE = STG_W'(NUM_STAGES - 1);

  logic [ADDR_W-1:0] cnt;
  logic              m_rot, m_rev;
  logic              legal_go, at_end;
  logic [ADDR_W-1:0] rotated, reversed;
  int                rot_digits;

  assign legal_go = start && !valid && !(rot_sel && rev_en);
  assign at_end   = (cnt == CNT_MAX) && (m_rot || stage == LAST_STAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      stage <= '0;
      m_rot <= 1'b0;
      m_rev <= 1'b0;
    end else begin
      done <= valid && at_end;
      if (legal_go) begin
        valid <= 1'b1;
        cnt   <= '0;
        stage <= '0;
        m_rot <= rot_sel;
        m_rev <= rev_en;
      end else if (valid) begin
        cnt <= cnt + 1'b1;
        if (at_end) begin
          valid <= 1'b0;
          stage <= '0;
          m_rot <= 1'b0;
          m_rev <= 1'b0;
        end else if (cnt == CNT_MAX) begin
          stage <= stage + 1'b1;
        end
      end
    end
  end

  always_comb begin
    rot_digits = m_rot ? (CARRY_ROT_DIGITS % DIGITS) : (int'(stage) % DIGITS);
    rotated    = ADDR_W'({cnt, cnt} >> (rot_digits * DIGIT_W));
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_rev
    assign reversed[d*DIGIT_W +: DIGIT_W] = rotated[(DIGITS-1-d)*DIGIT_W +: DIGIT_W];
  end

  assign addr = !valid ? '0 : (m_rev ? reversed : rotated);

  a_r7_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !valid);
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> done);
  a_r2_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (legal_go) |=> (valid && stage == '0 && cnt == '0));
  a_r8_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && start && rot_sel && rev_en) |=> !valid);
  a_r6_stage_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (stage <= LAST_STAGE));
  a_r6_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && stage != $past(stage)) |-> (stage == $past(stage) + 1'b1));
  a_r5_carry_single: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && m_rot) |-> (stage == '0));
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid)) |-> ($stable(m_rot) && $stable(m_rev)));
endmodule

// File: tb/tb_ntt_addr_gen.sv
module tb_ntt_addr_gen;
  localparam int DW = 2, DG = 2, CR = 1;
  localparam int AW = DW * DG, NS = DG + 1, SW = 2;
  localparam int RADIX = 1 << DW, NADDR = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, rot_sel = 0, rev_en = 0;
  logic [AW-1:0] addr;
  logic [SW-1:0] stage;
  logic valid, done;
  int errors = 0, checks = 0;

  ntt_addr_gen #(.DIGIT_W(DW), .DIGITS(DG), .CARRY_ROT_DIGITS(CR),
                 .ADDR_W(AW), .NUM_STAGES(NS), .STG_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rot_sel(rot_sel), .rev_en(rev_en),
    .addr(addr), .stage(stage), .valid(valid), .done(done));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pw(input int k);
    int p = 1;
    for (int i = 0; i < k; i++) p *= RADIX;
    return p;
  endfunction

  function automatic int exp_addr(input int c, input int k, input bit rv);
    int r, o;
    k = k % DG;
    r = (c / pw(k)) + (c % pw(k)) * pw(DG - k);
    if (!rv) return r;
    o = 0;
    for (int d = 0; d < DG; d++) o = o * RADIX + (r / pw(d)) % RADIX;
    return o;
  endfunction

  task automatic run(input bit rs, input bit rv, input bit disturb, input string req);
    int nst;
    nst = rs ? 1 : NS;
    @(negedge clk); start = 1; rot_sel = rs; rev_en = rv;
    @(negedge clk); start = 0; rot_sel = 0; rev_en = 0;
    for (int s = 0; s < nst; s++) begin
      for (int c = 0; c < NADDR; c++) begin
        int e;
        e = exp_addr(c, rs ? CR : s, rv);
        chk(valid === 1'b1, "R2/R6 valid", int'(valid), 1);
        chk(int'(stage) == s, rs ? "R5 stage" : "R6 stage", int'(stage), s);
        chk(int'(addr) == e, req, int'(addr), e);
        chk(done === 1'b0, "R7 no early done", int'(done), 0);
        if (disturb && s == 0 && c == 3) begin
          start = 1; rot_sel = !rs; rev_en = !rv;
        end
        @(negedge clk);
        start = 0; rot_sel = 0; rev_en = 0;
      end
    end
    chk(done === 1'b1, "R7 done pulse", int'(done), 1);
    chk(valid === 1'b0, "R7 valid low at done", int'(valid), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk(valid === 0 && done === 0, "R1 reset flags", int'(valid), 0);
    chk(addr === '0 && stage === '0, "R1 reset addr/stage", int'(addr), 0);
    rst_n = 1;
    @(negedge clk);
    run(0, 0, 0, "R3 forward addr");
    run(0, 1, 0, "R4 inverse addr");
    run(1, 0, 0, "R5 carry addr");
    @(negedge clk); start = 1; rot_sel = 1; rev_en = 1;
    @(negedge clk); start = 0; rot_sel = 0; rev_en = 0;
    for (int i = 0; i < 4; i++) begin
      chk(valid === 1'b0, "R8 illegal mode ignored", int'(valid), 0);
      chk(done === 1'b0, "R8 no done", int'(done), 0);
      @(negedge clk);
    end
    run(0, 0, 1, "R9 forward despite start");
    run(1, 0, 1, "R9 carry despite start");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule